// File: doc/BRIEF.md
# Framed Command Transmitter

This block pushes one outgoing command, byte by byte, into the write data port of a byte-wide security coprocessor that sits on a small four-register bus. A pulse on `start` captures a 32-bit payload length. The block first writes a wake-up value to the coprocessor's control register. It then throws away any stale bytes in the write port and any unread reply bytes in the read port. After that it sends a ten-byte framing preamble and finally the payload. The payload arrives from an upstream byte source over a valid/ready handshake.

The coprocessor bus is a simple strobe interface. `bus_rd` and `bus_wr` each mark a single-cycle access to the register selected by `bus_addr`, and read data is returned on `bus_rdata` in the same cycle as the read strobe. Before every byte goes into the write port, the block polls the status register until the transmit-empty flag is set. Between two unsuccessful polls it waits a programmable number of cycles. Every polling loop has a fixed bound. If a bound is reached, the block raises a sticky error flag and drops back to idle without writing anything more.

Top module: `ftx_cmd_sender`

## Requirements
- R1: After reset, the block is idle: `busy`, `done`, `err`, `in_ready`, `bus_rd` and `bus_wr` are all low.
- R2: The first bus access after an accepted `start` is a write of 0x41 to register 3 (control).
- R3: The write-port flush reads register 0 repeatedly. It ends on the read that returns 0xFF for the sixth time, counting since `start` and not requiring the 0xFF reads to be back to back, or else after 4096 reads, whichever comes first.
- R4: The read-port flush alternates a read of register 1 with a read of register 2 (status). It ends when status bit 7 (read data available) reads clear. If 5000 status reads in a row show bit 7 set, the block sets `err` and returns to idle.
- R5: Every write to register 0 is preceded, after the previous such write, by a status read with bit 0 (transmit empty) set.
- R6: When a status poll finds bit 0 clear, the next status poll starts exactly `poll_gap`+2 cycles after it, and no bus read is issued in the cycle right after the failed poll.
- R7: If 5000 status polls for one byte all find bit 0 clear, the block sets `err`, deasserts `busy`, and performs no further bus write.
- R8: The frame begins with these bytes, in this order: 0x01, 0x04, bits 15:8 and then bits 7:0 of (length+6), 0x01, 0x0B, then the 32-bit length with its most significant byte first.
- R9: Payload bytes are written to register 0 in arrival order. `in_ready` is high only in a payload slot after transmit-empty has been confirmed, and a stalled upstream source holds the block in that slot without losing data.
- R10: `done` is a one-cycle pulse in the cycle after the final byte is written. For a zero length, the final byte is the tenth preamble byte.
- R11: `err` stays set until the next accepted `start`, which clears it. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one command when idle |
| payload_len | input | 32 | Payload byte count, captured at start |
| poll_gap | input | 16 | Idle cycles inserted after a failed status poll |
| in_valid | input | 1 | Upstream payload byte valid |
| in_data | input | 8 | Upstream payload byte |
| in_ready | output | 1 | Payload byte taken this cycle when valid |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 2 | Register select: 0 write port, 1 read port, 2 status, 3 control |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the strobe cycle |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |

## Verification
A wrong sequencer state appears on the bus within one access. Examples are a write with the wrong register or byte, a missing status poll before a write, or a read where the gap should be idle. Each write is compared on the cycle it occurs against a queue of expected register and byte pairs. A counter or exit condition that is off by one appears only at the end of a phase. It is caught when the counts of reads per register are compared once the command has finished or timed out, and when the spacing between polls is measured against `poll_gap`.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WFL, ST_RFL_D, ST_RFL_S, ST_POLL, ST_GAP, ST_SEND
  } ftx_state_e;

  // register selects on the coprocessor bus
  localparam logic [1:0] OFS_WR   = 2'd0;
  localparam logic [1:0] OFS_RD   = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

  localparam logic [7:0] CTRL_WAKE = 8'h41;
  localparam logic [7:0] PROTO_VER = 8'h01;
  localparam logic [7:0] KIND_DATA = 8'h04;
  localparam logic [7:0] CHAN_CMD  = 8'h0B;
  localparam logic [7:0] DRAIN_MARK = 8'hFF;

  localparam int HDR_BYTES    = 10;
  localparam int OUTER_BIAS   = 6;
  localparam int STAT_XFE_BIT = 0;
  localparam int STAT_RDA_BIT = 7;

  // byte idx of the ten-byte preamble for a payload of len bytes
  function automatic logic [7:0] hdr_byte(input logic [3:0] idx, input logic [31:0] len);
    logic [31:0] outer;
    outer = len + 32'(OUTER_BIAS);
    case (idx)
      4'd0:    hdr_byte = PROTO_VER;
      4'd1:    hdr_byte = KIND_DATA;
      4'd2:    hdr_byte = outer[15:8];
      4'd3:    hdr_byte = outer[7:0];
      4'd4:    hdr_byte = PROTO_VER;
      4'd5:    hdr_byte = CHAN_CMD;
      4'd6:    hdr_byte = len[31:24];
      4'd7:    hdr_byte = len[23:16];
      4'd8:    hdr_byte = len[15:8];
      default: hdr_byte = len[7:0];
    endcase
  endfunction

endpackage

// File: rtl/ftx_byte_sel.sv
module ftx_byte_sel
  import ftx_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic [3:0]       idx,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       pay_byte,
  output logic [7:0]       byte_o
);
  logic in_hdr;
  assign in_hdr = idx < 4'(HDR_BYTES);
  assign byte_o = in_hdr ? hdr_byte(idx, 32'(len)) : pay_byte;
endmodule

// File: rtl/ftx_gap_timer.sv
module ftx_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             expired
);
  logic [GAP_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (load)         left <= gap;
    else if (left != '0)   left <= left - 1'b1;
  end

  assign expired = (left == '0);
endmodule

// File: rtl/ftx_cmd_sender.sv
module ftx_cmd_sender
  import ftx_pkg::*;
#(
  parameter int LEN_W       = 32,
  parameter int GAP_W       = 16,
  parameter int WFLUSH_MAX  = 4096,
  parameter int FF_EXIT     = 6,
  parameter int RFLUSH_MAX  = 5000,
  parameter int POLL_MAX    = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] payload_len,
  input  logic [GAP_W-1:0] poll_gap,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [1:0]       bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int CNT_TOP = (WFLUSH_MAX > RFLUSH_MAX)
                         ? ((WFLUSH_MAX > POLL_MAX) ? WFLUSH_MAX : POLL_MAX)
                         : ((RFLUSH_MAX > POLL_MAX) ? RFLUSH_MAX : POLL_MAX);
  localparam int CNT_W = $clog2(CNT_TOP + 1);
  localparam int FF_W  = $clog2(FF_EXIT + 1);

  ftx_state_e       st;
  logic [LEN_W-1:0] len_q, pay_left;
  logic [3:0]       idx;
  logic [CNT_W-1:0] cnt;
  logic [FF_W-1:0]  ff_seen;
  logic [7:0]       frame_byte;

  // named internal events
  logic start_ok, hdr_phase, is_ff, wfl_exit;
  logic rfl_clear, rfl_timeout, poll_hit, poll_miss, poll_timeout;
  logic gap_load, gap_done, byte_fire, last_byte;

  assign start_ok     = (st == ST_IDLE) && start;
  assign hdr_phase    = idx < 4'(HDR_BYTES);
  assign is_ff        = (bus_rdata == DRAIN_MARK);
  assign wfl_exit     = (is_ff && ff_seen == FF_W'(FF_EXIT - 1)) ||
                        (cnt == CNT_W'(WFLUSH_MAX - 1));
  assign rfl_clear    = (st == ST_RFL_S) && !bus_rdata[STAT_RDA_BIT];
  assign rfl_timeout  = (st == ST_RFL_S) && bus_rdata[STAT_RDA_BIT] &&
                        (cnt == CNT_W'(RFLUSH_MAX - 1));
  assign poll_hit     = (st == ST_POLL) && bus_rdata[STAT_XFE_BIT];
  assign poll_miss    = (st == ST_POLL) && !bus_rdata[STAT_XFE_BIT];
  assign poll_timeout = poll_miss && (cnt == CNT_W'(POLL_MAX - 1));
  assign gap_load     = poll_miss && !poll_timeout;
  assign last_byte    = hdr_phase ? (idx == 4'(HDR_BYTES - 1) && len_q == '0)
                                  : (pay_left == LEN_W'(1));

  ftx_byte_sel #(.LEN_W(LEN_W)) u_sel (
    .idx(idx), .len(len_q), .pay_byte(in_data), .byte_o(frame_byte)
  );

  ftx_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .gap(poll_gap), .expired(gap_done)
  );

  // bus drive
  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = OFS_WR;
    bus_wdata = frame_byte;
    in_ready  = 1'b0;
    case (st)
      ST_CMD:   begin bus_wr = 1'b1; bus_addr = OFS_CTRL; bus_wdata = CTRL_WAKE; end
      ST_WFL:   begin bus_rd = 1'b1; bus_addr = OFS_WR;   end
      ST_RFL_D: begin bus_rd = 1'b1; bus_addr = OFS_RD;   end
      ST_RFL_S: begin bus_rd = 1'b1; bus_addr = OFS_STAT; end
      ST_POLL:  begin bus_rd = 1'b1; bus_addr = OFS_STAT; end
      ST_SEND: begin
        in_ready = !hdr_phase;
        bus_wr   = hdr_phase || in_valid;
      end
      default: ;
    endcase
  end

  assign byte_fire = (st == ST_SEND) && bus_wr;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      len_q    <= '0;
      pay_left <= '0;
      idx      <= '0;
      cnt      <= '0;
      ff_seen  <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= byte_fire && last_byte;
      case (st)
        ST_IDLE: if (start_ok) begin
          len_q    <= payload_len;
          pay_left <= payload_len;
          idx      <= '0;
          err      <= 1'b0;
          st       <= ST_CMD;
        end
        ST_CMD: begin
          cnt     <= '0;
          ff_seen <= '0;
          st      <= ST_WFL;
        end
        ST_WFL: begin
          if (wfl_exit) begin
            cnt <= '0;
            st  <= ST_RFL_D;
          end else begin
            cnt <= cnt + 1'b1;
            if (is_ff) ff_seen <= ff_seen + 1'b1;
          end
        end
        ST_RFL_D: st <= ST_RFL_S;
        ST_RFL_S: begin
          if (rfl_clear) begin
            cnt <= '0;
            st  <= ST_POLL;
          end else if (rfl_timeout) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= ST_RFL_D;
          end
        end
        ST_POLL: begin
          if (poll_hit) begin
            st <= ST_SEND;
          end else if (poll_timeout) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= ST_GAP;
          end
        end
        ST_GAP: if (gap_done) st <= ST_POLL;
        ST_SEND: if (byte_fire) begin
          if (hdr_phase) idx <= idx + 1'b1;
          else           pay_left <= pay_left - 1'b1;
          cnt <= '0;
          st  <= last_byte ? ST_IDLE : ST_POLL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ftx_cmd_sender_chk.sv
module ftx_cmd_sender_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_valid,
  input logic       in_ready,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       poll_miss
);
  logic xfe_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   xfe_ok <= 1'b0;
    else if (bus_wr && bus_addr == 2'd0)          xfe_ok <= 1'b0;
    else if (bus_rd && bus_addr == 2'd2 && bus_rdata[0]) xfe_ok <= 1'b1;
  end

  assert_cmd_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_wr && bus_addr == 2'd3));

  assert_xfe_before_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |-> xfe_ok);

  assert_quiet_after_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_miss |=> !bus_rd);

  assert_halt_on_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !bus_wr));

  assert_ready_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |-> (bus_wr && bus_addr == 2'd0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

endmodule

bind ftx_cmd_sender ftx_cmd_sender_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .busy(busy), .done(done), .err(err), .poll_miss(poll_miss)
);

// File: tb/ftx_cmd_sender_bench.sv
module ftx_cmd_sender_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] payload_len = '0;
  logic [15:0] poll_gap = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, bus_rd, bus_wr, busy, done, err;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  ftx_cmd_sender u_ftx_cmd_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .payload_len(payload_len),
    .poll_gap(poll_gap), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err)
  );

  // ---------------- coprocessor register model ----------------
  int   wf_mode = 1;     // 0: write port reads 00, 1: always FF, 2: FF on odd reads
  int   rda_limit = 0;   // status reads that still show read data available
  int   xfe_mode = 1;    // 0: never empty, 1: always empty, 2: busy on every third read
  logic model_clr = 1'b0;
  int   wr_reads, rd_reads, st_reads;
  logic xfe_bit;

  always_ff @(posedge clk) begin
    if (model_clr) begin
      wr_reads <= 0; rd_reads <= 0; st_reads <= 0;
    end else if (bus_rd) begin
      case (bus_addr)
        2'd0: wr_reads <= wr_reads + 1;
        2'd1: rd_reads <= rd_reads + 1;
        2'd2: st_reads <= st_reads + 1;
        default: ;
      endcase
    end
  end

  always_comb begin
    xfe_bit = (xfe_mode == 1) ? 1'b1 : (xfe_mode == 2) ? (st_reads % 3 != 1) : 1'b0;
    case (bus_addr)
      2'd0:    bus_rdata = (wf_mode == 1 || (wf_mode == 2 && wr_reads % 2 == 1)) ? 8'hFF : 8'h00;
      2'd1:    bus_rdata = 8'h5A;
      2'd2:    bus_rdata = {(st_reads < rda_limit), 6'b0, xfe_bit};
      default: bus_rdata = 8'h00;
    endcase
  end

  // ---------------- scoreboard ----------------
  int n_chk = 0, n_fail = 0;
  logic [9:0] exp_q[$];
  int  done_cnt = 0, cyc = 0, last_wr_cyc = -10, last_st_cyc = 0, gap_cur = 0;
  bit  xfe_ok = 0, in_poll = 0, seen_exit = 0, last_b0 = 1, finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input int len);
    return 8'((i * 13 + len) & 255);
  endfunction

  task automatic push_frame(input int len);
    int outer;
    outer = len + 6;
    exp_q.push_back({2'd0, 8'h01});
    exp_q.push_back({2'd0, 8'h04});
    exp_q.push_back({2'd0, 8'((outer / 256) % 256)});
    exp_q.push_back({2'd0, 8'(outer % 256)});
    exp_q.push_back({2'd0, 8'h01});
    exp_q.push_back({2'd0, 8'h0B});
    for (int s = 3; s >= 0; s--) exp_q.push_back({2'd0, 8'((len >> (8 * s)) & 255)});
    for (int i = 0; i < len; i++) exp_q.push_back({2'd0, pay(i, len)});
  endtask

  // monitor: samples 5 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      cyc++;
      if (rst_n && bus_wr) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 R8", "unexpected write", {bus_addr, bus_wdata}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({bus_addr, bus_wdata} == e, (e[9:8] == 2'd3) ? "R2" : "R8 R9",
                "write addr/data", {bus_addr, bus_wdata}, e);
        end
        if (bus_addr == 2'd0) begin
          check(xfe_ok, "R5", "write without empty status", 0, 1);
          xfe_ok = 0;
        end
        last_wr_cyc = cyc;
      end
      if (rst_n && bus_rd && bus_addr == 2'd2) begin
        if (in_poll && !last_b0)
          check(cyc - last_st_cyc == gap_cur + 2, "R6", "poll spacing",
                cyc - last_st_cyc, gap_cur + 2);
        in_poll   = seen_exit;
        seen_exit = seen_exit | !bus_rdata[7];
        last_b0   = bus_rdata[0];
        last_st_cyc = cyc;
        if (bus_rdata[0]) xfe_ok = 1;
      end
      if (rst_n && done) begin
        check(exp_q.size() == 0 && last_wr_cyc == cyc - 1, "R10", "done timing",
              cyc - last_wr_cyc, 1);
        done_cnt++;
      end
    end
  end

  task automatic run_frame(input int len, input int gap, input int wfm, input int rdal,
                           input int xfm, input bit mid_start, input bit expect_err);
    int old;
    wf_mode = wfm; rda_limit = rdal; xfe_mode = xfm;
    model_clr = 1'b1;
    @(negedge clk);
    model_clr = 1'b0;
    exp_q.push_back({2'd3, 8'h41});
    if (!expect_err) push_frame(len);
    in_poll = 0; seen_exit = 0; xfe_ok = 0; last_b0 = 1; gap_cur = gap;
    old = done_cnt;
    payload_len = 32'(len); poll_gap = 16'(gap); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b0 && busy == 1'b1, "R11", "start clears err", err, 0);
    fork
      begin
        for (int i = 0; i < len; i++) begin
          if (err) break;
          if (i % 4 == 2) begin in_valid = 1'b0; @(negedge clk); end
          in_valid = 1'b1;
          in_data  = pay(i, len);
          #5;
          while (!in_ready && !err) begin @(negedge clk); #5; end
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin
        while (done_cnt == old && !err) @(negedge clk);
      end
      begin
        if (mid_start) begin
          repeat (40) @(negedge clk);
          payload_len = 32'd7; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, expect_err ? "R7" : "R9", "bytes left unsent", exp_q.size(), 0);
    check(busy == 1'b0, "R10", "idle after command", busy, 0);
    check(err == expect_err, "R7", "error flag", err, expect_err);
    exp_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clr = 1'b0;
    @(negedge clk);
    #5;
    check({busy, done, err, in_ready, bus_rd, bus_wr} == 6'b0, "R1", "reset state",
          {busy, done, err, in_ready, bus_rd, bus_wr}, 0);
    @(negedge clk);

    // short payload, write port floods 0xFF
    run_frame(5, 0, 1, 0, 1, 0, 0);
    check(wr_reads == 6, "R3", "flush reads on sixth FF", wr_reads, 6);

    // empty payload
    run_frame(0, 0, 1, 0, 1, 0, 0);

    // long payload, stalls, busy status, scattered FF, stale read data, ignored start
    run_frame(300, 3, 2, 3, 2, 1, 0);
    check(wr_reads == 12, "R3", "scattered FF count", wr_reads, 12);
    check(rd_reads == 4, "R4", "read port drain reads", rd_reads, 4);

    // write port never shows FF: bounded drain
    run_frame(2, 0, 0, 0, 1, 0, 0);
    check(wr_reads == 4096, "R3", "drain bound", wr_reads, 4096);

    // read data never drains
    run_frame(3, 0, 1, 1000000, 1, 0, 1);
    check(st_reads == 5000, "R4", "read drain bound", st_reads, 5000);
    repeat (10) @(negedge clk);
    check(err == 1'b1, "R11", "error held", err, 1);

    // transmit side never empties
    run_frame(4, 1, 1, 0, 0, 0, 1);
    check(st_reads == 5001, "R7", "poll bound", st_reads, 5001);

    // clean recovery
    run_frame(1, 2, 1, 0, 1, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule